// File: doc/BRIEF.md
# Converter Scan Sequencer

This block sits on the host side of an 8-bit, four-input parallel-bus analog-to-digital converter. It runs the converter in its write-then-read mode and uses the early-read method, where the read strobe is lowered a fixed delay after the write strobe rises and before the converter signals completion. The conversion and the read overlap, so one sample takes about one microsecond. The block drives chip select, write, read and the two-bit channel address. It waits for the active-low completion signal, captures the data bus, and hands each result to a valid/ready stream with a channel tag.

Channels are visited round-robin over an enable mask, and disabled inputs are skipped. Two address-latching styles are supported. In sample mode the converter latches the address when chip select falls, so the block raises and lowers chip select whenever the channel changes. In track mode the address is taken when write falls, and chip select stays low for the whole scan. Every interval is a parameter in clock cycles. If completion never arrives within a timeout, the block pulses an error flag, releases the bus and starts the scan again.

Top module: `adc_scan_seq`

## Requirements
- R1: While reset is high, and in the cycle after it is released, cs_n, wr_n and rd_n are high, and m_valid and err are low.
- R2: Results are tagged in round-robin order of enabled channels, ascending with wrap-around and skipping disabled ones. After reset or a timeout, the scan starts from the lowest enabled channel. The tag appears on m_chan.
- R3: Address value k selects converter input k, with addr bit 0 as the low select line. m_data carries the bus value present when the completion signal was seen low during a read of that channel.
- R4: wr_n stays low for exactly T_WR cycles per conversion.
- R5: rd_n falls exactly T_RD cycles after wr_n rises, while completion is still high. wr_n and rd_n are never low together.
- R6: No wr_n fall comes sooner than the mode's gap (T_GAP_S in sample mode, T_GAP_T in track mode) after the completion signal fell.
- R7: A pending result holds m_valid, m_data and m_chan steady until it is accepted. No new conversion starts while a result is pending.
- R8: If completion is not seen low within T_TMO cycles of rd_n falling, err is high for one cycle. In that same cycle rd_n and cs_n go high, and the scan restarts.
- R9: With an all-zero enable mask, cs_n stays high and no conversion starts.
- R10: In sample mode, addr only changes while cs_n is high. cs_n is raised between conversions of different channels and stays low across repeated conversions of one channel.
- R11: addr is stable while wr_n is low. In track mode, cs_n stays low for the whole scan.
- R12: rd_n rises in the same cycle that the captured result appears on m_valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_mode | input | 1 | 1: address latched on chip select fall; 0: address latched on write fall |
| chan_en | input | N_CH | Channel enable mask |
| cs_n | output | 1 | Converter chip select, active low |
| wr_n | output | 1 | Converter write / conversion start, active low |
| rd_n | output | 1 | Converter read, active low |
| addr | output | CH_W | Converter channel address |
| int_n | input | 1 | Converter completion signal, active low |
| db | input | DATA_W | Converter data bus |
| m_valid | output | 1 | Result stream valid |
| m_ready | input | 1 | Result stream ready |
| m_data | output | DATA_W | Result sample |
| m_chan | output | CH_W | Result channel tag |
| err | output | 1 | One-cycle pulse on a completion timeout |

## Verification
The strobe intervals are exact. The wr_n rise comes T_WR edges after its fall, rd_n falls T_RD edges after that, and err rises T_TMO edges after rd_n falls. The bench stamps every strobe transition with an edge count sampled on the falling clock edge and compares the differences with those numbers. A completion fall reaches the capture register three edges later (two synchronizer stages, then the state register), and m_valid and the rd_n release appear together at that edge. For this reason the gap is checked as a lower bound, and each result is checked at the falling edge after the rising edge that accepted it.

// File: rtl/scan_seq_pkg.sv
package scan_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // bus released, waiting for an enabled channel
    ST_ADDR,   // address driven, chip select about to fall
    ST_ARM,    // waiting for gap expiry and an empty output slot
    ST_WR,     // write strobe low
    ST_RDLY,   // write high, counting down to the early read
    ST_RD,     // read low, waiting for completion
    ST_NEXT    // result captured, choosing next channel
  } seq_state_t;

endpackage

// File: rtl/scan_pick.sv
module scan_pick #(
  parameter int N_CH = 4,
  localparam int CH_W = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic [N_CH-1:0] en,
  input  logic [CH_W-1:0] last,
  output logic [CH_W-1:0] nxt,
  output logic            any
);

  // Search downward so the nearest enabled channel after 'last' wins.
  always_comb begin
    nxt = last;
    any = 1'b0;
    for (int k = N_CH; k >= 1; k--) begin
      if (en[(int'(last) + k) % N_CH]) begin
        nxt = CH_W'((int'(last) + k) % N_CH);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/scan_timer.sv
module scan_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)               cnt <= '0;
    else if (load)         cnt <= val;
    else if (cnt != '0)    cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/scan_out_reg.sv
module scan_out_reg #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] d,
  input  logic [CH_W-1:0]   c,
  input  logic              m_ready,
  output logic              m_valid,
  output logic [DATA_W-1:0] m_data,
  output logic [CH_W-1:0]   m_chan
);

  always_ff @(posedge clk) begin
    if (rst)           m_valid <= 1'b0;
    else if (load)     m_valid <= 1'b1;
    else if (m_ready)  m_valid <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_data <= '0;
      m_chan <= '0;
    end else if (load) begin
      m_data <= d;
      m_chan <= c;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import scan_seq_pkg::*;
#(
  parameter int N_CH    = 4,
  parameter int DATA_W  = 8,
  parameter int T_WR    = 19,
  parameter int T_RD    = 28,
  parameter int T_GAP_S = 30,
  parameter int T_GAP_T = 24,
  parameter int T_TMO   = 200,
  parameter int SYNC_N  = 2,
  localparam int CH_W   = (N_CH > 1) ? $clog2(N_CH) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample_mode,
  input  logic [N_CH-1:0]   chan_en,
  output logic              cs_n,
  output logic              wr_n,
  output logic              rd_n,
  output logic [CH_W-1:0]   addr,
  input  logic              int_n,
  input  logic [DATA_W-1:0] db,
  output logic              m_valid,
  input  logic              m_ready,
  output logic [DATA_W-1:0] m_data,
  output logic [CH_W-1:0]   m_chan,
  output logic              err
);

  localparam int T_M1  = (T_WR > T_RD) ? T_WR : T_RD;
  localparam int T_M2  = (T_GAP_S > T_GAP_T) ? T_GAP_S : T_GAP_T;
  localparam int T_M3  = (T_M1 > T_M2) ? T_M1 : T_M2;
  localparam int T_MAX = (T_M3 > T_TMO) ? T_M3 : T_TMO;
  localparam int TW    = $clog2(T_MAX + 1);
  localparam logic [CH_W-1:0] CH_LAST = CH_W'(N_CH - 1);

  seq_state_t state;
  logic [CH_W-1:0] cur;

  // Completion synchronizer; depth picked by parameter.
  logic int_s;
  generate
    if (SYNC_N < 2) begin : g_sync1
      always_ff @(posedge clk) begin
        if (rst) int_s <= 1'b1;
        else     int_s <= int_n;
      end
    end else begin : g_syncn
      logic [SYNC_N-1:0] pipe;
      always_ff @(posedge clk) begin
        if (rst) pipe <= '1;
        else     pipe <= {pipe[SYNC_N-2:0], int_n};
      end
      assign int_s = pipe[SYNC_N-1];
    end
  endgenerate

  // Next enabled channel after the current one.
  logic [CH_W-1:0] pick_ch;
  logic            pick_any;

  scan_pick #(.N_CH(N_CH)) u_pick (
    .en   (chan_en),
    .last (cur),
    .nxt  (pick_ch),
    .any  (pick_any)
  );

  // Strobe interval timer.
  logic          step_load;
  logic [TW-1:0] step_val;
  logic          step_zero;

  scan_timer #(.W(TW)) u_step (
    .clk  (clk),
    .rst  (rst),
    .load (step_load),
    .val  (step_val),
    .zero (step_zero)
  );

  // Inter-conversion gap timer, started at capture.
  logic          capture;
  logic [TW-1:0] gap_val;
  logic          gap_zero;

  assign gap_val = sample_mode ? TW'(T_GAP_S) : TW'(T_GAP_T);

  scan_timer #(.W(TW)) u_gap (
    .clk  (clk),
    .rst  (rst),
    .load (capture),
    .val  (gap_val),
    .zero (gap_zero)
  );

  // Result holding register on the stream side.
  scan_out_reg #(.DATA_W(DATA_W), .CH_W(CH_W)) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (capture),
    .d       (db),
    .c       (cur),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .m_data  (m_data),
    .m_chan  (m_chan)
  );

  logic go;
  assign go      = (state == ST_ARM) && gap_zero && !m_valid;
  assign capture = (state == ST_RD) && !int_s;

  always_comb begin
    step_load = 1'b0;
    step_val  = '0;
    unique case (state)
      ST_ARM: if (go) begin
        step_load = 1'b1;
        step_val  = TW'(T_WR - 1);
      end
      ST_WR: if (step_zero) begin
        step_load = 1'b1;
        step_val  = TW'(T_RD - 1);
      end
      ST_RDLY: if (step_zero) begin
        step_load = 1'b1;
        step_val  = TW'(T_TMO - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cs_n  <= 1'b1;
      wr_n  <= 1'b1;
      rd_n  <= 1'b1;
      addr  <= '0;
      cur   <= CH_LAST;
      err   <= 1'b0;
    end else begin
      err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (pick_any) begin
            addr  <= pick_ch;
            cur   <= pick_ch;
            state <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          cs_n  <= 1'b0;
          state <= ST_ARM;
        end
        ST_ARM: begin
          if (go) begin
            wr_n  <= 1'b0;
            state <= ST_WR;
          end
        end
        ST_WR: begin
          if (step_zero) begin
            wr_n  <= 1'b1;
            state <= ST_RDLY;
          end
        end
        ST_RDLY: begin
          if (step_zero) begin
            rd_n  <= 1'b0;
            state <= ST_RD;
          end
        end
        ST_RD: begin
          if (!int_s) begin
            rd_n  <= 1'b1;
            state <= ST_NEXT;
          end else if (step_zero) begin
            err   <= 1'b1;
            rd_n  <= 1'b1;
            cs_n  <= 1'b1;
            cur   <= CH_LAST;
            state <= ST_IDLE;
          end
        end
        ST_NEXT: begin
          if (!pick_any) begin
            cs_n  <= 1'b1;
            state <= ST_IDLE;
          end else if (sample_mode && (pick_ch != cur)) begin
            cs_n  <= 1'b1;
            addr  <= pick_ch;
            cur   <= pick_ch;
            state <= ST_ADDR;
          end else begin
            addr  <= pick_ch;
            cur   <= pick_ch;
            state <= ST_ARM;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int N_CH   = 4,
  parameter int CH_W   = 2,
  parameter int DATA_W = 8,
  parameter int T_WR   = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              sample_mode,
  input logic [N_CH-1:0]   chan_en,
  input logic              cs_n,
  input logic              wr_n,
  input logic              rd_n,
  input logic [CH_W-1:0]   addr,
  input logic              m_valid,
  input logic              m_ready,
  input logic [DATA_W-1:0] m_data,
  input logic [CH_W-1:0]   m_chan,
  input logic              err
);

  logic [31:0] wr_low_cnt;
  always_ff @(posedge clk) begin
    if (rst || wr_n) wr_low_cnt <= '0;
    else             wr_low_cnt <= wr_low_cnt + 1'b1;
  end

  // R4
  wr_width_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> (wr_low_cnt == 32'(T_WR)));

  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~wr_n, ~rd_n}));

  // R7
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data) && $stable(m_chan)));

  // R7
  no_start_pending_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && $past(wr_n)) |-> !$past(m_valid));

  // R8
  timeout_release_chk: assert property (@(posedge clk) disable iff (rst)
    err |-> (cs_n && rd_n));

  // R9
  idle_mask_chk: assert property (@(posedge clk) disable iff (rst)
    ((chan_en == '0) && ($past(chan_en) == '0) && $past(cs_n)) |-> cs_n);

  // R10
  addr_cs_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (sample_mode && !cs_n && !$past(cs_n)) |-> $stable(addr));

  // R11
  addr_wr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!wr_n && !$past(wr_n)) |-> $stable(addr));

  // R12
  rd_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(m_valid) |-> $rose(rd_n));

endmodule

bind adc_scan_seq adc_scan_seq_chk #(
  .N_CH(N_CH), .CH_W(CH_W), .DATA_W(DATA_W), .T_WR(T_WR)
) u_chk (
  .clk(clk), .rst(rst), .sample_mode(sample_mode), .chan_en(chan_en),
  .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
  .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
  .err(err)
);

// File: tb/adc_scan_seq_tb.sv
module adc_scan_seq_tb;

  localparam int N_CH    = 4;
  localparam int T_WR    = 10;
  localparam int T_RD    = 14;
  localparam int T_GAP_S = 15;
  localparam int T_GAP_T = 12;
  localparam int T_TMO   = 40;
  localparam int INT_DLY = 12;
  localparam int WD_CYC  = 150000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sample_mode = 1'b1;
  logic [3:0] chan_en = 4'hF;
  logic       cs_n, wr_n, rd_n;
  logic [1:0] addr;
  logic       int_n = 1'b1;
  logic [7:0] db = 8'h00;
  logic       m_valid;
  logic       m_ready = 1'b0;
  logic [7:0] m_data;
  logic [1:0] m_chan;
  logic       err;

  always #10 clk = ~clk;

  adc_scan_seq #(
    .N_CH(N_CH), .DATA_W(8), .T_WR(T_WR), .T_RD(T_RD),
    .T_GAP_S(T_GAP_S), .T_GAP_T(T_GAP_T), .T_TMO(T_TMO), .SYNC_N(2)
  ) u_dut (
    .clk(clk), .rst(rst), .sample_mode(sample_mode), .chan_en(chan_en),
    .cs_n(cs_n), .wr_n(wr_n), .rd_n(rd_n), .addr(addr),
    .int_n(int_n), .db(db),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data), .m_chan(m_chan),
    .err(err)
  );

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // bench state shared between the stimulus and the monitor
  int  cyc = 0;
  int  n_samples, sb_idx, exp_last, mdl_idx;
  int  cs_rise, wr_fall_cnt, err_cnt, last_int_cyc;
  int  ready_ctl = 2;   // 0 low, 1 high, 2 random
  bit  no_int = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  function automatic logic [7:0] dat_of(input int ch, input int idx);
    return 8'((idx * 29 + ch * 64 + 7) & 255);
  endfunction

  function automatic int next_ch(input logic [3:0] m, input int last);
    for (int k = 1; k <= 4; k++)
      if (m[(last + k) % 4]) return (last + k) % 4;
    return last;
  endfunction

  // Converter model and monitor, both on the falling edge.
  initial begin
    bit pcs, pwr, prd, pmv, pmr;
    logic [7:0] pdata;
    logic [1:0] pchan;
    int lat_ch, dly, wr_fall_cyc, wr_rise_cyc, rd_fall_cyc, ec;
    pcs = 1; pwr = 1; prd = 1; pmv = 0; pmr = 0; pdata = 0; pchan = 0;
    lat_ch = 0; dly = 0; wr_fall_cyc = 0; wr_rise_cyc = 0; rd_fall_cyc = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (rst) begin
        int_n = 1'b1;
        dly = 0;
      end else begin
        // converter side
        if (pcs && !cs_n && sample_mode) lat_ch = int'(addr);
        if (pwr && !wr_n && !sample_mode) lat_ch = int'(addr);
        if (prd && !rd_n && !no_int) dly = INT_DLY;
        if (!prd && rd_n) begin int_n = 1'b1; dly = 0; end
        if (dly > 0) begin
          dly--;
          if (dly == 0) begin
            db = dat_of(lat_ch, mdl_idx);
            mdl_idx++;
            int_n = 1'b0;
            last_int_cyc = cyc;
          end
        end
        // strobe timing
        if (pwr && !wr_n) begin
          wr_fall_cyc = cyc;
          wr_fall_cnt++;
          chk(!m_valid, "R7 start while pending", int'(m_valid), 0);
          if (last_int_cyc >= 0)
            chk(cyc - last_int_cyc >= (sample_mode ? T_GAP_S : T_GAP_T), "R6 gap",
                cyc - last_int_cyc, sample_mode ? T_GAP_S : T_GAP_T);
        end
        if (!pwr && wr_n) begin
          wr_rise_cyc = cyc;
          chk(cyc - wr_fall_cyc == T_WR, "R4 write width", cyc - wr_fall_cyc, T_WR);
        end
        if (prd && !rd_n) begin
          rd_fall_cyc = cyc;
          chk(cyc - wr_rise_cyc == T_RD, "R5 read delay", cyc - wr_rise_cyc, T_RD);
          chk(int_n == 1'b1, "R5 read before completion", int'(int_n), 1);
        end
        if (!pcs && cs_n) cs_rise++;
        if (err) begin
          err_cnt++;
          chk(cs_n && rd_n, "R8 release", int'({cs_n, rd_n}), 3);
          chk(cyc - rd_fall_cyc == T_TMO, "R8 timeout delay", cyc - rd_fall_cyc, T_TMO);
          exp_last = 3;
        end
        // stream side
        if (!pmv && m_valid)
          chk(rd_n && !prd, "R12 read release", int'({prd, rd_n}), 1);
        if (pmv && pmr) begin
          ec = next_ch(chan_en, exp_last);
          chk(int'(pchan) == ec, "R2 channel tag", int'(pchan), ec);
          chk(pdata == dat_of(ec, sb_idx), "R3 data", int'(pdata), int'(dat_of(ec, sb_idx)));
          exp_last = ec;
          sb_idx++;
          n_samples++;
        end
        if (pmv && !pmr)
          chk(m_valid && m_data == pdata && m_chan == pchan, "R7 hold",
              int'(m_data), int'(pdata));
      end
      pcs = cs_n; pwr = wr_n; prd = rd_n;
      pmv = m_valid; pdata = m_data; pchan = m_chan;
      case (ready_ctl)
        0:       m_ready = 1'b0;
        1:       m_ready = 1'b1;
        default: m_ready = (($urandom % 4) != 0);
      endcase
      pmr = m_ready;
    end
  end

  task automatic do_reset(input bit mode, input logic [3:0] mask);
    @(posedge clk); #1;
    rst = 1'b1;
    sample_mode = mode;
    chan_en = mask;
    no_int = 0;
    ready_ctl = 2;
    repeat (3) @(posedge clk);
    #1;
    n_samples = 0; sb_idx = 0; exp_last = 3; mdl_idx = 0;
    cs_rise = 0; wr_fall_cnt = 0; err_cnt = 0; last_int_cyc = -1;
    rst = 1'b0;
  endtask

  task automatic wait_samples(input int n);
    int t;
    t = 0;
    while (n_samples < n && t < 20000) begin
      @(posedge clk);
      t++;
    end
    chk(n_samples >= n, "watchdog samples", n_samples, n);
  endtask

  initial begin
    void'($urandom(32'h2C41));
    // R1: reset values
    do_reset(1'b1, 4'hF);
    chk(cs_n && wr_n && rd_n, "R1 strobes", int'({cs_n, wr_n, rd_n}), 7);
    chk(!m_valid, "R1 valid", int'(m_valid), 0);
    chk(!err, "R1 err", int'(err), 0);

    // R2 R3 R10: sample mode, all channels
    wait_samples(12);

    // R11: track mode, channel 2 disabled
    do_reset(1'b0, 4'b1011);
    wait_samples(12);
    chk(cs_rise == 0, "R11 cs low in track mode", cs_rise, 0);

    // R10: sample mode, single channel keeps cs low
    do_reset(1'b1, 4'b0100);
    wait_samples(6);
    chk(cs_rise == 0, "R10 single channel cs", cs_rise, 0);

    // R10: sample mode, alternating channels toggle cs
    do_reset(1'b1, 4'b0101);
    wait_samples(6);
    chk(cs_rise >= 5, "R10 cs toggles", cs_rise, 5);

    // R7: backpressure
    do_reset(1'b1, 4'b0011);
    ready_ctl = 0;
    repeat (300) @(posedge clk);
    #1;
    chk(wr_fall_cnt == 1, "R7 stall", wr_fall_cnt, 1);
    chk(m_valid == 1'b1, "R7 pending valid", int'(m_valid), 1);
    ready_ctl = 2;
    wait_samples(4);

    // R8: completion timeout and restart
    do_reset(1'b0, 4'b0110);
    no_int = 1;
    begin
      int t;
      t = 0;
      while (err_cnt == 0 && t < 5000) begin
        @(posedge clk);
        t++;
      end
      #1;
      no_int = 0;
    end
    wait_samples(4);
    chk(err_cnt == 1, "R8 single pulse", err_cnt, 1);

    // R9: empty mask
    do_reset(1'b1, 4'b0000);
    repeat (100) @(posedge clk);
    #1;
    chk(wr_fall_cnt == 0, "R9 no conversion", wr_fall_cnt, 0);
    chk(cs_n == 1'b1, "R9 cs high", int'(cs_n), 1);

    // random phases: R2 R3 R4 R5 R6
    for (int p = 0; p < 6; p++) begin
      do_reset(1'($urandom % 2), 4'(($urandom % 15) + 1));
      wait_samples(15);
    end

    finish_run();
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

endmodule